// File: doc/BRIEF.md
# Index Delta Prediction Buffer

This block guesses the upper cache-set index bits of a memory access before address translation has finished. A small table, selected by a slice of the load or store instruction address, holds a k-bit wrap-around offset for each entry. On lookup, the offset for the instruction is added to the speculative bits of the virtual address, and the carry out is dropped. The result is the index the cache uses to pick a set while the translation is still in flight.

Once the physical address is known, the update port gives the same instruction address with both the virtual and the physical speculative bits. The buffer works out (physical − virtual) mod 2^k and stores it in the selected entry. The next access from that instruction, or from any instruction that aliases to the same entry, then applies the same offset. Storing an offset rather than the bits themselves lets one entry serve every page of a region that was mapped as one contiguous block. When k is 1, the offset is just a flag that says whether to flip the bit.

Top module: `index_delta_buffer`

## Requirements
- R1: After reset every stored offset is zero, so the predicted index equals the lookup's virtual bits.
- R2: The entry is chosen by bits [PC_LSB +: log2(ENTRIES)] of the instruction address, which is bits [7:2] by default. Higher address bits do not take part, so two addresses that differ only above that slice share one entry.
- R3: The predicted index is (virtual bits + stored offset) mod 2^K. It is combinational from the lookup inputs, and any carry out of the K-bit sum is discarded.
- R4: When upd_valid is high at a rising clock edge, the selected entry takes (physical bits − virtual bits) mod 2^K. When upd_valid is low, no entry changes, whatever the other update inputs hold.
- R5: A lookup and an update that select the same entry in the same cycle give a prediction made from the offset held before that edge. The new offset is used from the next cycle on.
- R6: An update changes only the entry its address selects. All other entries keep their offsets.
- R7: With K = 1 the prediction is the virtual bit XOR the stored flag, and the flag is set exactly when the physical and virtual bits differ.
- R8: After an update, a lookup by the same instruction with the same virtual bits predicts exactly the physical bits that were given in that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears all offsets |
| lkp_pc | input | PC_W | Instruction address of the access being predicted |
| lkp_vbits | input | K | Speculative index bits taken from the virtual address |
| lkp_pred | output | K | Predicted index bits, (lkp_vbits + offset) mod 2^K |
| upd_valid | input | 1 | Writes the update's offset at the next rising edge |
| upd_pc | input | PC_W | Instruction address whose entry is rewritten |
| upd_vbits | input | K | Virtual speculative bits of the translated access |
| upd_pbits | input | K | Physical bits found by translation at the same positions |

## Verification
The assertions assume that upd_valid and the update fields are driven to known values in every cycle that reset is released. They also assume that the lookup inputs are settled by the time the combinational prediction is checked. The bench meets this by driving all inputs only on the falling edge, and by holding upd_valid low with deliberately non-zero data in its idle cycles. The random phase draws instruction addresses from a small pool that contains addresses aliasing to one entry. This makes same-entry lookup/update collisions and rewrites of neighbouring entries frequent. A second instance with K = 1 runs on the same stimulus.

// File: rtl/idb_pkg.sv
package idb_pkg;

  localparam int unsigned IDB_MAX_W = 8;

  typedef logic [IDB_MAX_W-1:0] idb_word_t;

  // Mask with the low w bits set
  function automatic idb_word_t idb_mask(input int unsigned w);
    idb_word_t m;
    m = '0;
    for (int unsigned i = 0; i < IDB_MAX_W; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    return m;
  endfunction

  // (a + b) mod 2^w, carry out dropped
  function automatic idb_word_t idb_wrap_add(input idb_word_t a, input idb_word_t b,
                                             input int unsigned w);
    return (a + b) & idb_mask(w);
  endfunction

  // (a - b) mod 2^w, borrow dropped
  function automatic idb_word_t idb_wrap_sub(input idb_word_t a, input idb_word_t b,
                                             input int unsigned w);
    return (a - b) & idb_mask(w);
  endfunction

endpackage

// File: rtl/idb_slot_sel.sv
module idb_slot_sel #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned PC_LSB = 2,
  parameter int unsigned SLOT_W = 6
) (
  input  logic [PC_W-1:0]   pc,
  output logic [SLOT_W-1:0] slot
);
  // R2: a fixed slice of the instruction address; upper bits take no part
  assign slot = pc[PC_LSB +: SLOT_W];

  initial begin
    assert (PC_LSB + SLOT_W <= PC_W)
      else $error("slot slice exceeds instruction address width");
  end
endmodule

// File: rtl/idb_delta_store.sv
module idb_delta_store #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned K       = 2,
  localparam int unsigned SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [K-1:0]      wdelta,
  input  logic [SLOT_W-1:0] rslot,
  output logic [K-1:0]      rdelta
);
  logic [ENTRIES-1:0][K-1:0] mem;

  // R1 clear on reset; R4 single-entry write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (we) begin
      mem[wslot] <= wdelta;
    end
  end

  // R5: read sees the contents from before the edge (no bypass)
  assign rdelta = mem[rslot];

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(wslot)] == $past(wdelta)));

  assert_idle_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));

  generate
    for (genvar e = 0; e < int'(ENTRIES); e++) begin : g_keep
      assert_others_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wslot != SLOT_W'(e))) |=> $stable(mem[e]));
    end
  endgenerate
endmodule

// File: rtl/idb_index_form.sv
module idb_index_form #(
  parameter int unsigned K = 2
) (
  input  logic         rst_n,
  input  logic [K-1:0] vbits,
  input  logic [K-1:0] delta,
  output logic [K-1:0] pred
);
  import idb_pkg::*;

  generate
    if (K == 1) begin : g_flip
      // R7: single bit, offset is a flip flag
      assign pred = delta[0] ? ~vbits : vbits;

      always_comb begin
        if (rst_n) assert_flip_is_xor_R7: assert (pred == (vbits ^ delta));
      end
    end else begin : g_add
      // R3: modular add, carry dropped
      idb_word_t sum_w;
      assign sum_w = idb_wrap_add(idb_word_t'(vbits), idb_word_t'(delta), K);
      assign pred  = sum_w[K-1:0];
    end
  endgenerate

  // R3: subtracting the virtual bits back out recovers the offset
  always_comb begin
    if (rst_n) assert_pred_inverts_R3: assert (K'(pred - vbits) == delta);
  end
endmodule

// File: rtl/index_delta_buffer.sv
module index_delta_buffer #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned K       = 2,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned PC_LSB  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lkp_pc,
  input  logic [K-1:0]    lkp_vbits,
  output logic [K-1:0]    lkp_pred,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [K-1:0]    upd_vbits,
  input  logic [K-1:0]    upd_pbits
);
  import idb_pkg::*;

  localparam int unsigned SLOT_W = $clog2(ENTRIES);

  // Named internal events for assertions
  logic [SLOT_W-1:0] lkp_slot;
  logic [SLOT_W-1:0] upd_slot;
  logic              upd_we;
  logic [K-1:0]      wr_delta;
  logic [K-1:0]      rd_delta;
  idb_word_t         wr_delta_w;

  initial begin
    assert (K >= 1 && K <= IDB_MAX_W) else $error("K out of range");
    assert (ENTRIES >= 2 && (1 << SLOT_W) == ENTRIES)
      else $error("ENTRIES must be a power of two");
  end

  idb_slot_sel #(.PC_W(PC_W), .PC_LSB(PC_LSB), .SLOT_W(SLOT_W)) u_lkp_sel (
    .pc(lkp_pc), .slot(lkp_slot)
  );

  idb_slot_sel #(.PC_W(PC_W), .PC_LSB(PC_LSB), .SLOT_W(SLOT_W)) u_upd_sel (
    .pc(upd_pc), .slot(upd_slot)
  );

  // R4: offset is physical minus virtual, modulo 2^K
  assign upd_we     = upd_valid;
  assign wr_delta_w = idb_wrap_sub(idb_word_t'(upd_pbits), idb_word_t'(upd_vbits), K);
  assign wr_delta   = wr_delta_w[K-1:0];

  idb_delta_store #(.ENTRIES(ENTRIES), .K(K)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(upd_we), .wslot(upd_slot), .wdelta(wr_delta),
    .rslot(lkp_slot), .rdelta(rd_delta)
  );

  idb_index_form #(.K(K)) u_form (
    .rst_n(rst_n), .vbits(lkp_vbits), .delta(rd_delta), .pred(lkp_pred)
  );

  // R8: the stored offset maps the update's virtual bits onto its physical bits
  always_comb begin
    if (rst_n) assert_offset_maps_R8: assert (K'(upd_vbits + wr_delta) == upd_pbits);
  end

  // R5: a same-entry update is not visible to the lookup in its own cycle
  assert_old_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_we && (upd_slot == lkp_slot)) |=>
      (K'($past(lkp_pred) - $past(lkp_vbits)) == $past(rd_delta)));
endmodule

// File: tb/index_delta_buffer_tb.sv
module index_delta_buffer_tb;
  localparam int ENT = 64;
  localparam int K   = 2;
  localparam int MOD = 1 << K;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lkp_pc = '0;
  logic [K-1:0] lkp_vbits = '0;
  logic [K-1:0] lkp_pred;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [K-1:0] upd_vbits = '0;
  logic [K-1:0] upd_pbits = '0;
  logic        k1_v = 1'b0;
  logic        k1_uv = 1'b0;
  logic        k1_up = 1'b0;
  logic        k1_pred;

  int checks = 0;
  int errors = 0;
  int model2 [ENT];
  int model1 [ENT];
  bit done = 0;

  always #4 clk = ~clk;

  index_delta_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_vbits(lkp_vbits),
    .lkp_pred(lkp_pred), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_vbits(upd_vbits), .upd_pbits(upd_pbits)
  );

  index_delta_buffer #(.K(1)) u_dut_k1 (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_vbits(k1_v),
    .lkp_pred(k1_pred), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_vbits(k1_uv), .upd_pbits(k1_up)
  );

  function automatic int entry_of(input logic [31:0] pc);
    return int'((pc / 4) % ENT);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: inputs are set just after a falling edge, outputs checked
  // before the rising edge, model written at the rising edge.
  task automatic cyc(input logic [31:0] lpc, input int lv, input bit uv,
                     input logic [31:0] upc, input int uvb, input int upb,
                     input string req);
    int e;
    lkp_pc = lpc; lkp_vbits = K'(lv);
    upd_valid = uv; upd_pc = upc; upd_vbits = K'(uvb); upd_pbits = K'(upb);
    k1_v = lv[0]; k1_uv = uvb[0]; k1_up = upb[0];
    #2;
    e = entry_of(lpc);
    chk(req, int'(lkp_pred), (lv + model2[e]) % MOD);
    chk("R7", int'(k1_pred), (lv % 2) ^ model1[e]);
    @(posedge clk);
    if (uv) begin
      model2[entry_of(upc)] = ((upb - uvb) % MOD + MOD) % MOD;
      model1[entry_of(upc)] = (upb % 2) ^ (uvb % 2);
    end
    @(negedge clk);
  endtask

  initial begin
    int cyc_n = 0;
    while (!done) begin
      @(posedge clk);
      cyc_n++;
      if (cyc_n > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] pool [16];
    for (int i = 0; i < ENT; i++) begin model2[i] = 0; model1[i] = 0; end
    for (int i = 0; i < 16; i++)
      pool[i] = (i < 12) ? 32'(i * 4 + 32'h1000) : 32'(32'h2000 + (i - 12) * 256);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every entry starts with a zero offset (idle update data non-zero)
    for (int s = 0; s < ENT; s++) cyc(32'(s * 4), 3, 1'b0, 32'h4, 1, 2, "R1");

    // R4: idle update with data leaves entry unchanged
    cyc(32'h10, 1, 1'b0, 32'h10, 0, 3, "R4");
    cyc(32'h10, 1, 1'b0, 32'h10, 0, 0, "R4");
    // R4/R8: write offset 3 (p=0, v=1), then same v gives p back
    cyc(32'h20, 0, 1'b1, 32'h20, 1, 0, "R4");
    cyc(32'h20, 1, 1'b0, 32'h0, 0, 0, "R8");
    // R3: carry discarded, 2 + 3 -> 1
    cyc(32'h20, 2, 1'b0, 32'h0, 0, 0, "R3");
    // R2: address differing above the slice aliases to the same entry
    cyc(32'h20 + 32'h100, 2, 1'b0, 32'h0, 0, 0, "R2");
    cyc(32'hFFFF_FF20, 3, 1'b0, 32'h0, 0, 0, "R2");
    // R6: neighbours untouched
    cyc(32'h1C, 2, 1'b0, 32'h0, 0, 0, "R6");
    cyc(32'h24, 2, 1'b0, 32'h0, 0, 0, "R6");
    // R5: same-entry lookup and update in one cycle uses old offset
    cyc(32'h20, 1, 1'b1, 32'h120, 0, 1, "R5");
    cyc(32'h20, 1, 1'b0, 32'h0, 0, 0, "R5");
    // R7: flip flag for the single-bit instance
    cyc(32'h30, 0, 1'b1, 32'h30, 1, 0, "R7");
    cyc(32'h30, 1, 1'b0, 32'h0, 0, 0, "R7");
    cyc(32'h30, 0, 1'b1, 32'h30, 1, 1, "R7");
    cyc(32'h30, 1, 1'b0, 32'h0, 0, 0, "R7");

    // Random traffic compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      cyc(pool[$urandom_range(15)], int'($urandom_range(MOD - 1)),
          bit'($urandom_range(1)), pool[$urandom_range(15)],
          int'($urandom_range(MOD - 1)), int'($urandom_range(MOD - 1)), "R3");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule